// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block turns a reference clock frequency (kHz) and a requested PLL output rate (kbps) into a packed 16-bit PLL setup word. It first finds the input divider. The divider starts at 1 and moves up one step per clock as long as the reference, divided by the next divider value, stays at or above a minimum post-divide reference frequency. The divider never goes above 31.

With the divider fixed, the block computes the multiplier as a rounded-up quotient. It then computes the output rate that the chosen coefficients actually give, and takes a frequency-range code from that achieved rate, not from the requested one. Both quotients come from one shared restoring divider that runs over several cycles.

Software or a sequencer starts a job with a one-cycle `start` pulse. It reads the setup word, the achieved rate and an overflow flag when `done` pulses.

Top module: `pll_coef_search`

## Requirements
- R1: During reset and after it, `done`, `busy`, `mul_ovf`, `cfg_word` and `achieved_kbps` are all zero until the first job completes.
- R2: A reference input of 0 is treated as 2000 kHz for the whole job.
- R3: The divider is the value d that results from starting at 1 and incrementing while floor(ref/(d+1)) >= 2000 and d < 31; it is placed in `cfg_word[12:8]`.
- R4: The raw multiplier is ceil(want × d / ref).
- R5: If the raw multiplier exceeds 255, the multiplier field is 255 and `mul_ovf` is 1; otherwise the field holds the raw value and `mul_ovf` is 0.
- R6: `achieved_kbps` equals floor(ref × m / d), where m is the multiplier after saturation.
- R7: The range code in `cfg_word[15:14]` is 3 if the achieved rate is >= 501000, 2 if >= 251000, 1 if >= 126000, and 0 otherwise.
- R8: `cfg_word` has the range code in bits 15:14, 0 in bit 13, the divider in bits 12:8 and the multiplier in bits 7:0.
- R9: `busy` is 1 from the cycle after an accepted start until the result is ready. `done` is then high for exactly one cycle with `busy` low, and the result outputs hold until the next job completes.
- R10: A `start` while `busy` is 1 is ignored: the job in flight finishes with its own inputs, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, sampled only when idle |
| ref_khz | input | FREQ_W | Reference frequency in kHz |
| want_kbps | input | RATE_W | Requested PLL output rate in kbps |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| cfg_word | output | 16 | Packed range code, divider and multiplier |
| achieved_kbps | output | FREQ_W+8 | Output rate the chosen coefficients give |
| mul_ovf | output | 1 | Multiplier was saturated to 255 |

## Verification
The assertions assume three things. First, `ref_khz` and `want_kbps` matter only in the cycle a start is accepted. Second, the range thresholds are in ascending order. Third, the products want × 31 and ref × 255 fit in the internal operand width at the default widths.

The stimulus drives inputs only on the falling edge. It keeps every value within the port widths and holds inputs steady during a job. It sweeps reference values on both sides of each divider step, including 0, and requested rates that cross every range threshold and the saturation point. The expected results come from an arithmetic model inside the bench.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int DIV_BITS  = 5;
  localparam int MUL_BITS  = 8;
  localparam int CFG_BITS  = 16;
  localparam int DIV_LIMIT = 31;

  typedef logic [DIV_BITS-1:0] coef_div_t;
  typedef logic [MUL_BITS-1:0] coef_mul_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_MUL  = 2'd2,
    S_RATE = 2'd3
  } srch_state_t;
endpackage

// File: rtl/pll_srch_prescan.sv
module pll_srch_prescan
  import pll_srch_pkg::*;
#(
  parameter int FREQ_W      = 20,
  parameter int MIN_REF_KHZ = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FREQ_W-1:0] ref_khz,
  output coef_div_t         div_val,
  output logic              fin
);
  localparam int PROD_W = FREQ_W + DIV_BITS + 1;

  logic             active;
  logic [PROD_W-1:0] need;
  logic             step_ok;

  // the next divider is allowed while ref >= MIN * (d+1)
  assign need    = PROD_W'(MIN_REF_KHZ) * PROD_W'({1'b0, div_val} + 6'd1);
  assign step_ok = (div_val != coef_div_t'(DIV_LIMIT)) && (PROD_W'(ref_khz) >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_val <= coef_div_t'(1);
      active  <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        div_val <= coef_div_t'(1);
        active  <= 1'b1;
      end else if (active) begin
        if (step_ok) begin
          div_val <= div_val + coef_div_t'(1);
        end else begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_srch_divider.sv
module pll_srch_divider #(
  parameter int NW = 28,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quot,
  output logic          done
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem;
  logic [DW:0]   shifted;
  logic [DW:0]   rem_next;
  logic          ge;
  logic [CW-1:0] cnt;
  logic          run;

  always_comb begin
    shifted  = {rem[DW-1:0], quot[NW-1]};
    ge       = shifted >= {1'b0, den};
    rem_next = ge ? (shifted - {1'b0, den}) : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      quot <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem  <= '0;
        quot <= num;
        cnt  <= CW'(NW);
        run  <= 1'b1;
      end else if (run) begin
        rem  <= rem_next;
        quot <= {quot[NW-2:0], ge};
        cnt  <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_srch_encoder.sv
module pll_srch_encoder
  import pll_srch_pkg::*;
#(
  parameter int ACH_W = 28,
  parameter int THR1  = 126000,
  parameter int THR2  = 251000,
  parameter int THR3  = 501000
) (
  input  logic [ACH_W-1:0]    rate,
  input  coef_div_t           div_val,
  input  coef_mul_t           mul_val,
  output logic [1:0]          range_code,
  output logic [CFG_BITS-1:0] word
);
  always_comb begin
    if (rate >= ACH_W'(THR3))      range_code = 2'd3;
    else if (rate >= ACH_W'(THR2)) range_code = 2'd2;
    else if (rate >= ACH_W'(THR1)) range_code = 2'd1;
    else                           range_code = 2'd0;
    word = {range_code, 1'b0, div_val, mul_val};
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_srch_pkg::*;
#(
  parameter int FREQ_W      = 20,
  parameter int RATE_W      = 20,
  parameter int MIN_REF_KHZ = 2000,
  parameter int THR1        = 126000,
  parameter int THR2        = 251000,
  parameter int THR3        = 501000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FREQ_W-1:0]     ref_khz,
  input  logic [RATE_W-1:0]     want_kbps,
  output logic                  busy,
  output logic                  done,
  output logic [CFG_BITS-1:0]   cfg_word,
  output logic [FREQ_W+7:0]     achieved_kbps,
  output logic                  mul_ovf
);
  localparam int ACH_W = FREQ_W + MUL_BITS;
  localparam int NUM_A = RATE_W + DIV_BITS + 1;
  localparam int NUM_B = FREQ_W + MUL_BITS;
  localparam int NUM_W = (NUM_A > NUM_B) ? NUM_A : NUM_B;

  srch_state_t         st;
  logic [FREQ_W-1:0]   ref_q;
  logic [RATE_W-1:0]   want_q;
  logic [NUM_W-1:0]    op_num;
  logic [FREQ_W-1:0]   op_den;
  logic                dv_go;
  logic                dv_done;
  logic [NUM_W-1:0]    dv_quot;
  coef_div_t           div_w;
  logic                scan_fin;
  logic                accept;
  coef_mul_t           mul_q;
  logic                ovf_q;
  logic                sat;
  coef_mul_t           mul_sat;
  logic [1:0]          range_w;
  logic [CFG_BITS-1:0] enc_word;

  assign accept  = start && (st == S_IDLE);
  assign busy    = (st != S_IDLE);
  assign sat     = |dv_quot[NUM_W-1:MUL_BITS];
  assign mul_sat = sat ? coef_mul_t'('1) : dv_quot[MUL_BITS-1:0];

  pll_srch_prescan #(
    .FREQ_W      (FREQ_W),
    .MIN_REF_KHZ (MIN_REF_KHZ)
  ) u_scan (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .ref_khz (ref_q),
    .div_val (div_w),
    .fin     (scan_fin)
  );

  pll_srch_divider #(
    .NW (NUM_W),
    .DW (FREQ_W)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (dv_go),
    .num  (op_num),
    .den  (op_den),
    .quot (dv_quot),
    .done (dv_done)
  );

  pll_srch_encoder #(
    .ACH_W (ACH_W),
    .THR1  (THR1),
    .THR2  (THR2),
    .THR3  (THR3)
  ) u_enc (
    .rate       (dv_quot[ACH_W-1:0]),
    .div_val    (div_w),
    .mul_val    (mul_q),
    .range_code (range_w),
    .word       (enc_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      ref_q         <= '0;
      want_q        <= '0;
      op_num        <= '0;
      op_den        <= '0;
      dv_go         <= 1'b0;
      mul_q         <= '0;
      ovf_q         <= 1'b0;
      cfg_word      <= '0;
      achieved_kbps <= '0;
      mul_ovf       <= 1'b0;
      done          <= 1'b0;
    end else begin
      dv_go <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            ref_q  <= (ref_khz == '0) ? FREQ_W'(MIN_REF_KHZ) : ref_khz;
            want_q <= want_kbps;
            st     <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (scan_fin) begin
            // ceiling division: (want*d + ref - 1) / ref
            op_num <= NUM_W'(want_q) * NUM_W'(div_w) + NUM_W'(ref_q) - NUM_W'(1);
            op_den <= ref_q;
            dv_go  <= 1'b1;
            st     <= S_MUL;
          end
        end
        S_MUL: begin
          if (dv_done) begin
            mul_q  <= mul_sat;
            ovf_q  <= sat;
            op_num <= NUM_W'(ref_q) * NUM_W'(mul_sat);
            op_den <= FREQ_W'(div_w);
            dv_go  <= 1'b1;
            st     <= S_RATE;
          end
        end
        S_RATE: begin
          if (dv_done) begin
            cfg_word      <= enc_word;
            achieved_kbps <= dv_quot[ACH_W-1:0];
            mul_ovf       <= ovf_q;
            done          <= 1'b1;
            st            <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
  parameter int FREQ_W = 20,
  parameter int RATE_W = 20,
  parameter int ACH_W  = 28,
  parameter int THR1   = 126000,
  parameter int THR3   = 501000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [15:0]       cfg_word,
  input logic [ACH_W-1:0]  achieved_kbps,
  input logic              mul_ovf,
  input logic [FREQ_W-1:0] lat_ref,
  input logic [RATE_W-1:0] lat_want
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r10_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(lat_ref) && $stable(lat_want)));

  a_r2_ref_nonzero: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(busy)) |-> (lat_ref != '0));

  a_r3_div_nonzero: assert property (@(posedge clk) disable iff (rst)
    done |-> (cfg_word[12:8] != 5'd0));

  a_r5_saturated: assert property (@(posedge clk) disable iff (rst)
    (done && mul_ovf) |-> (cfg_word[7:0] == 8'hFF));

  a_r8_gap_bit: assert property (@(posedge clk) disable iff (rst)
    done |-> !cfg_word[13]);

  a_r7_top_range: assert property (@(posedge clk) disable iff (rst)
    (done && cfg_word[15:14] == 2'd3) |-> (achieved_kbps >= ACH_W'(THR3)));

  a_r7_low_range: assert property (@(posedge clk) disable iff (rst)
    (done && achieved_kbps < ACH_W'(THR1)) |-> (cfg_word[15:14] == 2'd0));
endmodule

bind pll_coef_search pll_coef_search_chk #(
  .FREQ_W (FREQ_W),
  .RATE_W (RATE_W),
  .ACH_W  (ACH_W),
  .THR1   (THR1),
  .THR3   (THR3)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .cfg_word      (cfg_word),
  .achieved_kbps (achieved_kbps),
  .mul_ovf       (mul_ovf),
  .lat_ref       (ref_q),
  .lat_want      (want_q)
);

// File: tb/test_pll_coef_search.sv
module test_pll_coef_search;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W = 20;
  localparam int RATE_W = 20;
  localparam int ACH_W  = FREQ_W + 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] ref_khz = '0;
  logic [RATE_W-1:0] want_kbps = '0;
  logic              busy;
  logic              done;
  logic [15:0]       cfg_word;
  logic [ACH_W-1:0]  achieved_kbps;
  logic              mul_ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  pll_coef_search i_pll_coef_search (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .ref_khz       (ref_khz),
    .want_kbps     (want_kbps),
    .busy          (busy),
    .done          (done),
    .cfg_word      (cfg_word),
    .achieved_kbps (achieved_kbps),
    .mul_ovf       (mul_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog: actual=%0d cycles expected<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input longint r0, input longint w, output longint d, output longint m,
                       output bit o, output longint a, output longint rg);
    longint r;
    r = (r0 == 0) ? 2000 : r0;
    d = 1;
    while (d < 31 && (r / (d + 1)) >= 2000) d++;
    m = (w * d + r - 1) / r;
    o = (m > 255);
    if (o) m = 255;
    a = (r * m) / d;
    if (a >= 501000) rg = 3;
    else if (a >= 251000) rg = 2;
    else if (a >= 126000) rg = 1;
    else rg = 0;
  endtask

  task automatic wait_done(output bit got);
    int n = 0;
    got = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    got = done;
    chk(got, "R9 done arrives", longint'(done), 1);
  endtask

  task automatic run_job(input longint r, input longint w, input string tag);
    longint d, m, a, rg;
    bit o, got;
    model(r, w, d, m, o, a, rg);
    @(negedge clk);
    start = 1; ref_khz = FREQ_W'(r); want_kbps = RATE_W'(w);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R9 busy after start", longint'(busy), 1);
    wait_done(got);
    if (got) begin
      chk(cfg_word[12:8] == d[4:0], {tag, " R3 divider"}, longint'(cfg_word[12:8]), d);
      chk(cfg_word[7:0] == m[7:0], {tag, " R4 R5 multiplier"}, longint'(cfg_word[7:0]), m);
      chk(mul_ovf == o, {tag, " R5 overflow"}, longint'(mul_ovf), longint'(o));
      chk(longint'(achieved_kbps) == a, {tag, " R6 achieved"}, longint'(achieved_kbps), a);
      chk(cfg_word[15:14] == rg[1:0], {tag, " R7 range"}, longint'(cfg_word[15:14]), rg);
      chk(cfg_word[13] == 1'b0, {tag, " R8 gap bit"}, longint'(cfg_word[13]), 0);
      chk(busy == 1'b0, "R9 idle with done", longint'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", longint'(done), 0);
    end
  endtask

  initial begin
    longint refs[16] = '{0, 1, 999, 1999, 2000, 3999, 4000, 5999, 6000, 26000,
                         61999, 62000, 63999, 64000, 500000, 1048575};
    longint wants[8] = '{0, 1, 1000, 126000, 251000, 501000, 750000, 1048575};
    logic [15:0] hold_cfg;
    bit got;
    int extra;

    repeat (3) @(negedge clk);
    chk(done == 0 && busy == 0 && mul_ovf == 0, "R1 reset flags",
        longint'({done, busy, mul_ovf}), 0);
    chk(cfg_word == 0 && achieved_kbps == 0, "R1 reset data",
        longint'(cfg_word), 0);
    rst = 0;
    @(negedge clk);
    chk(cfg_word == 0 && !busy, "R1 after reset", longint'(cfg_word), 0);

    // zero reference handled as 2000 kHz
    run_job(0, 10000, "R2 zero ref");
    chk(cfg_word[12:8] == 5'd1 && cfg_word[7:0] == 8'd5, "R2 zero ref word",
        longint'(cfg_word[12:0]), 13'h0105);

    // range thresholds
    run_job(2000, 124000, "R7 below1");
    chk(cfg_word[15:14] == 2'd0, "R7 below 126000", longint'(cfg_word[15:14]), 0);
    run_job(2000, 125000, "R7 at1");
    chk(cfg_word[15:14] == 2'd1, "R7 at 126000", longint'(cfg_word[15:14]), 1);
    run_job(1000, 250000, "R7 below2");
    chk(cfg_word[15:14] == 2'd1, "R7 below 251000", longint'(cfg_word[15:14]), 1);
    run_job(1000, 251000, "R7 at2");
    chk(cfg_word[15:14] == 2'd2, "R7 at 251000", longint'(cfg_word[15:14]), 2);
    run_job(3000, 501000, "R7 at3");
    chk(cfg_word[15:14] == 2'd3, "R7 at 501000", longint'(cfg_word[15:14]), 3);

    // saturation
    run_job(1000, 300000, "R5 sat");
    chk(mul_ovf == 1 && cfg_word[7:0] == 8'hFF, "R5 saturation", longint'(cfg_word[7:0]), 255);
    chk(achieved_kbps == ACH_W'(255000), "R6 saturated rate", longint'(achieved_kbps), 255000);

    // divider clamp and packing
    run_job(1048575, 126000, "R3 clamp");
    chk(cfg_word[12:8] == 5'd31, "R3 clamp to 31", longint'(cfg_word[12:8]), 31);

    // outputs hold after done
    hold_cfg = cfg_word;
    repeat (4) @(negedge clk);
    chk(cfg_word == hold_cfg && !done, "R9 result holds", longint'(cfg_word), longint'(hold_cfg));

    // sweep
    foreach (refs[i]) begin
      foreach (wants[j]) begin
        run_job(refs[i], wants[j], "sweep");
      end
    end

    // start while busy is ignored
    @(negedge clk);
    start = 1; ref_khz = FREQ_W'(62000); want_kbps = RATE_W'(126000);
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    start = 1; ref_khz = FREQ_W'(1000); want_kbps = RATE_W'(300000);
    @(negedge clk);
    start = 0;
    wait_done(got);
    begin
      longint d, m, a, rg;
      bit o;
      model(62000, 126000, d, m, o, a, rg);
      chk(cfg_word[12:8] == d[4:0] && cfg_word[7:0] == m[7:0], "R10 first job kept",
          longint'(cfg_word[12:0]), (d << 8) | m);
      chk(mul_ovf == 1'b0, "R10 no overflow from ignored start", longint'(mul_ovf), 0);
    end
    extra = 0;
    @(negedge clk);
    for (int k = 0; k < 300; k++) begin
      if (done) extra++;
      @(negedge clk);
    end
    chk(extra == 0 && !busy, "R10 no second done", extra, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule